// File: doc/BRIEF.md
# DTMF Receive Timing Qualifier

This block sits behind a tone-pair recogniser that reports, once per clock, whether a valid dual-tone pair is present and which 4-bit key it is. It turns that raw and possibly chattering indication into a clean key code plus a strobe. Software waits for the strobe's rising edge and latches the code then. Guard timing decides when a tone is long enough to count, which short dropouts are bridged, and how long the line must stay silent before the output is cleared. All durations are counted from a 1 ms tick. Sub-millisecond windows use a 0.1 ms tick. Both ticks are one-cycle pulses supplied by the surroundings.

Two timing sets are available. Normal mode favours immunity to speech and noise. Fast mode shortens every window. The mode input is read continuously and is meant to change only while the block is idle. A synchronous power-down input returns everything to idle at once.

Top module: `dtmf_rx_qualifier`

## Requirements
- R1: After reset the key code output is 0000 and the strobe is low.
- R2: In normal mode a tone with a steady code, present for 49 counted ms ticks, is accepted: the code output takes that key and the strobe then rises.
- R3: In normal mode a tone shorter than 49 ms (for example 20 ms or 45 ms) produces no strobe and leaves the code at 0000.
- R4: In fast mode the acceptance length is 35 ms, so a 40 ms tone is accepted and a 30 ms tone is not.
- R5: Before acceptance, a dropout shorter than four 0.1 ms ticks resumes qualification with the ms count kept. A dropout of four or more such ticks abandons the tone, and a later tone starts again from zero.
- R6: Once accepted, the strobe and code stay set until the line has been silent for 30 ms ticks (normal) or 21 ms ticks (fast), counted from the end of the tone. The strobe and code then return to low and 0000 together.
- R7: While the strobe is high, a dropout shorter than 10 ms ticks (normal) or 3 ms ticks (fast) that is followed by the tone returning leaves the strobe and code untouched, and the hold continues.
- R8: While the strobe is high, a change of key code on the input does not change the code output.
- R9: A dropout of at least the R7 length starts release. Tone returning after that point does not cancel the release, which completes at the R6 silence count. A tone still present afterwards must then qualify again from zero.
- R10: The code output is updated first. The strobe rises six 0.1 ms ticks later, about 0.6 ms, and the code does not change on the cycle the strobe rises.
- R11: Power-down, on the next clock edge, forces the code to 0000, the strobe low and the block to idle.
- R12: During qualification a change of input code restarts the ms count with the new key, so two back-to-back 30 ms keys are both rejected in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Synchronous power-down, forces idle |
| fast_i | input | 1 | 1 selects the fast timing set |
| tick_ms_i | input | 1 | One-cycle pulse every 1 ms |
| tick_sub_i | input | 1 | One-cycle pulse every 0.1 ms |
| tone_vld_i | input | 1 | Recogniser reports a valid tone pair |
| tone_code_i | input | 4 | Key code from the recogniser |
| rx_code_o | output | 4 | Qualified key code, 0000 when idle |
| strobe_o | output | 1 | High while a qualified key is held |

## Verification
The bench sends steady tones just above and below each acceptance length in both modes. This separates the two threshold sets from each other and from the rejection behaviour. Dropouts of 0.2 ms and 1 ms before acceptance check whether qualification resumes or restarts. Dropouts of 2, 5 and 15 ms after acceptance separate a bridged break from one that starts release, including a tone that comes back during release. Key changes before and after acceptance check that a mid-qualification swap restarts the count while a mid-output swap is ignored. Power-down pulses land during an active hold. A behavioural model tracks every cycle.

// File: rtl/dtmf_rxq_pkg.sv
package dtmf_rxq_pkg;
  parameter int CNT_W  = 8;
  parameter int CODE_W = 4;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUALIFY,
    ST_BRIDGE_PRE,
    ST_PRESENT,
    ST_OUTPUT,
    ST_BRIDGE_HOLD,
    ST_RELEASE
  } rxq_state_e;

  // True when the tick that is arriving now completes a window of lim ticks.
  function automatic logic window_done(cnt_t count, cnt_t lim);
    return (count + cnt_t'(1)) >= lim;
  endfunction
endpackage

// File: rtl/dtmf_rxq_counter.sv
module dtmf_rxq_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val <= '0;
    else if (clr) val <= '0;
    else if (inc) val <= val + ONE;
  end
endmodule

// File: rtl/dtmf_rxq_limits.sv
module dtmf_rxq_limits
  import dtmf_rxq_pkg::*;
#(
  parameter int ACC_NORM   = 49,
  parameter int ACC_FAST   = 35,
  parameter int BRK_NORM   = 10,
  parameter int BRK_FAST   = 3,
  parameter int QUIET_NORM = 30,
  parameter int QUIET_FAST = 21
) (
  input  logic fast,
  output cnt_t acc_lim,
  output cnt_t brk_lim,
  output cnt_t quiet_lim
);
  localparam cnt_t ACC_N = cnt_t'(ACC_NORM);
  localparam cnt_t ACC_F = cnt_t'(ACC_FAST);
  localparam cnt_t BRK_N = cnt_t'(BRK_NORM);
  localparam cnt_t BRK_F = cnt_t'(BRK_FAST);
  localparam cnt_t QT_N  = cnt_t'(QUIET_NORM);
  localparam cnt_t QT_F  = cnt_t'(QUIET_FAST);

  always_comb begin
    acc_lim   = fast ? ACC_F : ACC_N;
    brk_lim   = fast ? BRK_F : BRK_N;
    quiet_lim = fast ? QT_F  : QT_N;
  end
endmodule

// File: rtl/dtmf_rxq_outreg.sv
module dtmf_rxq_outreg
  import dtmf_rxq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  load,
  input  code_t code_in,
  input  logic  set_stb,
  output code_t rx_code,
  output logic  strobe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_code <= '0;
      strobe  <= 1'b0;
    end else if (clr) begin
      rx_code <= '0;
      strobe  <= 1'b0;
    end else begin
      if (load)    rx_code <= code_in;
      if (set_stb) strobe  <= 1'b1;
    end
  end
endmodule

// File: rtl/dtmf_rx_qualifier.sv
module dtmf_rx_qualifier
  import dtmf_rxq_pkg::*;
#(
  parameter int ACC_NORM   = 49,
  parameter int ACC_FAST   = 35,
  parameter int BRK_NORM   = 10,
  parameter int BRK_FAST   = 3,
  parameter int QUIET_NORM = 30,
  parameter int QUIET_FAST = 21,
  parameter int PRE_SUBS   = 4,
  parameter int STB_SUBS   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_i,
  input  logic              fast_i,
  input  logic              tick_ms_i,
  input  logic              tick_sub_i,
  input  logic              tone_vld_i,
  input  logic [CODE_W-1:0] tone_code_i,
  output logic [CODE_W-1:0] rx_code_o,
  output logic              strobe_o
);
  localparam cnt_t PRE_LIM = cnt_t'(PRE_SUBS);
  localparam cnt_t STB_LIM = cnt_t'(STB_SUBS);

  rxq_state_e st, st_nxt;
  code_t      cur_code;
  cnt_t       ms_cnt, sub_cnt;
  cnt_t       acc_lim, brk_lim, quiet_lim;
  logic       ms_clr, ms_inc, sub_clr, sub_inc;
  logic       cap_code, load_out, set_stb, clr_out;

  // Named internal events, brought out for the checker.
  logic       accept_evt;
  logic       release_evt;
  code_t      qual_code;

  dtmf_rxq_limits #(
    .ACC_NORM(ACC_NORM), .ACC_FAST(ACC_FAST),
    .BRK_NORM(BRK_NORM), .BRK_FAST(BRK_FAST),
    .QUIET_NORM(QUIET_NORM), .QUIET_FAST(QUIET_FAST)
  ) u_limits (
    .fast(fast_i), .acc_lim(acc_lim), .brk_lim(brk_lim), .quiet_lim(quiet_lim)
  );

  dtmf_rxq_counter #(.W(CNT_W)) u_ms_cnt (
    .clk(clk), .rst_n(rst_n), .clr(ms_clr), .inc(ms_inc), .val(ms_cnt)
  );

  dtmf_rxq_counter #(.W(CNT_W)) u_sub_cnt (
    .clk(clk), .rst_n(rst_n), .clr(sub_clr), .inc(sub_inc), .val(sub_cnt)
  );

  dtmf_rxq_outreg u_out (
    .clk(clk), .rst_n(rst_n), .clr(clr_out), .load(load_out),
    .code_in(cur_code), .set_stb(set_stb),
    .rx_code(rx_code_o), .strobe(strobe_o)
  );

  always_comb begin
    st_nxt   = st;
    ms_clr   = 1'b0;
    ms_inc   = 1'b0;
    sub_clr  = 1'b0;
    sub_inc  = 1'b0;
    cap_code = 1'b0;
    load_out = 1'b0;
    set_stb  = 1'b0;
    clr_out  = 1'b0;
    if (pd_i) begin
      st_nxt  = ST_IDLE;
      ms_clr  = 1'b1;
      sub_clr = 1'b1;
      clr_out = 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (tone_vld_i) begin
            st_nxt   = ST_QUALIFY;
            cap_code = 1'b1;
            ms_clr   = 1'b1;
          end
        end
        ST_QUALIFY: begin
          if (!tone_vld_i) begin
            st_nxt  = ST_BRIDGE_PRE;
            sub_clr = 1'b1;
          end else if (tone_code_i != cur_code) begin
            cap_code = 1'b1;
            ms_clr   = 1'b1;
          end else if (tick_ms_i) begin
            if (window_done(ms_cnt, acc_lim)) begin
              st_nxt   = ST_PRESENT;
              load_out = 1'b1;
              sub_clr  = 1'b1;
            end else begin
              ms_inc = 1'b1;
            end
          end
        end
        ST_BRIDGE_PRE: begin
          if (tone_vld_i) begin
            st_nxt = ST_QUALIFY;
          end else if (tick_sub_i) begin
            if (window_done(sub_cnt, PRE_LIM)) st_nxt = ST_IDLE;
            else                              sub_inc = 1'b1;
          end
        end
        ST_PRESENT: begin
          if (tick_sub_i) begin
            if (window_done(sub_cnt, STB_LIM)) begin
              st_nxt  = ST_OUTPUT;
              set_stb = 1'b1;
            end else begin
              sub_inc = 1'b1;
            end
          end
        end
        ST_OUTPUT: begin
          if (!tone_vld_i) begin
            st_nxt = ST_BRIDGE_HOLD;
            ms_clr = 1'b1;
          end
        end
        ST_BRIDGE_HOLD: begin
          if (tone_vld_i) begin
            st_nxt = ST_OUTPUT;
          end else if (tick_ms_i) begin
            ms_inc = 1'b1;
            if (window_done(ms_cnt, brk_lim)) st_nxt = ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          if (tick_ms_i) begin
            if (window_done(ms_cnt, quiet_lim)) begin
              st_nxt  = ST_IDLE;
              clr_out = 1'b1;
              ms_clr  = 1'b1;
            end else begin
              ms_inc = 1'b1;
            end
          end
        end
        default: st_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_code <= '0;
    end else begin
      st <= st_nxt;
      if (pd_i)          cur_code <= '0;
      else if (cap_code) cur_code <= tone_code_i;
    end
  end

  assign accept_evt  = load_out;
  assign release_evt = clr_out & ~pd_i;
  assign qual_code   = cur_code;
endmodule

// File: rtl/dtmf_rxq_chk.sv
module dtmf_rxq_chk
  import dtmf_rxq_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  pd_i,
  input logic  strobe_o,
  input code_t rx_code_o,
  input logic  accept_evt,
  input logic  release_evt,
  input code_t qual_code
);
  // R10
  strobe_rise_code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> $stable(rx_code_o));

  // R8
  held_code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && $past(strobe_o)) |-> $stable(rx_code_o));

  // R11
  pd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |=> (!strobe_o && rx_code_o == '0));

  // R6
  release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> (!strobe_o && rx_code_o == '0));

  // R6
  strobe_fall_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> rx_code_o == '0);

  // R2
  accept_loads_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (rx_code_o == $past(qual_code) && !strobe_o));
endmodule

bind dtmf_rx_qualifier dtmf_rxq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd_i(pd_i), .strobe_o(strobe_o),
  .rx_code_o(rx_code_o), .accept_evt(accept_evt),
  .release_evt(release_evt), .qual_code(qual_code)
);

// File: tb/dtmf_rx_qualifier_tb.sv
module dtmf_rx_qualifier_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_i = 1'b0;
  logic       fast_i = 1'b0;
  logic       tick_ms_i = 1'b0;
  logic       tick_sub_i = 1'b0;
  logic       tone_vld_i = 1'b0;
  logic [3:0] tone_code_i = 4'd0;
  logic [3:0] rx_code_o;
  logic       strobe_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dtmf_rx_qualifier u_dut (
    .clk(clk), .rst_n(rst_n), .pd_i(pd_i), .fast_i(fast_i),
    .tick_ms_i(tick_ms_i), .tick_sub_i(tick_sub_i),
    .tone_vld_i(tone_vld_i), .tone_code_i(tone_code_i),
    .rx_code_o(rx_code_o), .strobe_o(strobe_o)
  );

  // Tick source: 10 cycles per 0.1 ms, 100 cycles per ms.
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt <= tcnt + 1;
    tick_sub_i <= ((tcnt % 10) == 9);
    tick_ms_i  <= ((tcnt % 100) == 99);
  end

  // Behavioural reference: phase names and integer run lengths.
  int m_phase = 0;  // 0 idle 1 measuring 2 short gap 3 waiting strobe 4 holding 5 gap after hold 6 releasing
  int m_run = 0;
  int m_sub = 0;
  int m_key = 0;
  int m_code = 0;
  int m_stb = 0;
  always @(posedge clk) begin
    int acc_n, brk_n, qt_n;
    acc_n = fast_i ? 35 : 49;
    brk_n = fast_i ? 3 : 10;
    qt_n  = fast_i ? 21 : 30;
    if (!rst_n || pd_i) begin
      m_phase = 0; m_run = 0; m_sub = 0; m_code = 0; m_stb = 0;
      if (pd_i) m_key = 0;
      if (!rst_n) m_key = 0;
    end else if (m_phase == 0) begin
      if (tone_vld_i) begin m_phase = 1; m_key = tone_code_i; m_run = 0; end
    end else if (m_phase == 1) begin
      if (!tone_vld_i) begin m_phase = 2; m_sub = 0; end
      else if (tone_code_i != m_key) begin m_key = tone_code_i; m_run = 0; end
      else if (tick_ms_i) begin
        if (m_run + 1 >= acc_n) begin m_phase = 3; m_code = m_key; m_sub = 0; end
        else m_run++;
      end
    end else if (m_phase == 2) begin
      if (tone_vld_i) m_phase = 1;
      else if (tick_sub_i) begin
        if (m_sub + 1 >= 4) m_phase = 0; else m_sub++;
      end
    end else if (m_phase == 3) begin
      if (tick_sub_i) begin
        if (m_sub + 1 >= 6) begin m_phase = 4; m_stb = 1; end else m_sub++;
      end
    end else if (m_phase == 4) begin
      if (!tone_vld_i) begin m_phase = 5; m_run = 0; end
    end else if (m_phase == 5) begin
      if (tone_vld_i) m_phase = 4;
      else if (tick_ms_i) begin
        if (m_run + 1 >= brk_n) m_phase = 6;
        m_run++;
      end
    end else begin
      if (tick_ms_i) begin
        if (m_run + 1 >= qt_n) begin m_phase = 0; m_code = 0; m_stb = 0; m_run = 0; end
        else m_run++;
      end
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && !done) begin
      n_chk++;
      if (rx_code_o != 4'(m_code) || strobe_o != m_stb[0]) begin
        n_fail++;
        $display("FAIL model %s: code %0d strobe %0d, expected code %0d strobe %0d",
                 cur_req, rx_code_o, strobe_o, m_code, m_stb);
      end
    end
  end

  task automatic expect_out(input string req, input int ecode, input int estb);
    n_chk++;
    if (rx_code_o != 4'(ecode) || strobe_o != estb[0]) begin
      n_fail++;
      $display("FAIL %s: code %0d strobe %0d, expected code %0d strobe %0d",
               req, rx_code_o, strobe_o, ecode, estb);
    end
  endtask

  task automatic wait_ms(input int ms);
    repeat (ms * 100) @(negedge clk);
  endtask

  task automatic tone(input bit v, input int code);
    @(negedge clk);
    tone_vld_i  = v;
    tone_code_i = 4'(code);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (195000) @(negedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    int dly;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    expect_out("R1", 0, 0);

    // R2 + R10: normal accept, code before strobe
    cur_req = "R2";
    tone(1, 5);
    dly = 0;
    while (rx_code_o == 4'd0 && dly < 6000) begin @(negedge clk); dly++; end
    cur_req = "R10";
    expect_out("R10", 5, 0);
    dly = 0;
    while (!strobe_o && dly < 200) begin @(negedge clk); dly++; end
    n_chk++;
    if (dly < 45 || dly > 65) begin
      n_fail++;
      $display("FAIL R10: strobe delay %0d cycles, expected 45..65", dly);
    end
    wait_ms(5);
    expect_out("R2", 5, 1);

    // R6: normal release after 30 ms silence
    cur_req = "R6";
    tone(0, 5);
    wait_ms(28);
    expect_out("R6", 5, 1);
    wait_ms(3);
    expect_out("R6", 0, 0);
    wait_ms(2);

    // R3: short tones rejected
    cur_req = "R3";
    tone(1, 2); wait_ms(20); tone(0, 2); wait_ms(5);
    expect_out("R3", 0, 0);
    tone(1, 3); wait_ms(45); tone(0, 3); wait_ms(1);
    expect_out("R3", 0, 0);
    wait_ms(3);

    // R12: key swap during qualification restarts count
    cur_req = "R12";
    tone(1, 3); wait_ms(30); tone(1, 4); wait_ms(30); tone(0, 4); wait_ms(1);
    expect_out("R12", 0, 0);
    wait_ms(3);

    // R5: short pre-acceptance gap bridged, longer gap restarts
    cur_req = "R5";
    tone(1, 7); wait_ms(20); tone(0, 7);
    repeat (20) @(negedge clk);
    tone(1, 7); wait_ms(35);
    expect_out("R5", 7, 1);
    tone(0, 7); wait_ms(33);
    expect_out("R6", 0, 0);
    tone(1, 8); wait_ms(20); tone(0, 8); wait_ms(1);
    tone(1, 8); wait_ms(40);
    expect_out("R5", 0, 0);
    tone(0, 8); wait_ms(3);

    // R7 + R8: bridged hold gap, key swap ignored
    cur_req = "R7";
    tone(1, 9); wait_ms(52);
    expect_out("R7", 9, 1);
    tone(0, 9); wait_ms(5);
    tone(1, 9); wait_ms(10);
    expect_out("R7", 9, 1);
    cur_req = "R8";
    tone(1, 12); wait_ms(15);
    expect_out("R8", 9, 1);

    // R9: long gap starts release that a returning tone does not cancel
    cur_req = "R9";
    tone(0, 12); wait_ms(15);
    tone(1, 12); wait_ms(5);
    expect_out("R9", 9, 1);
    wait_ms(12);
    expect_out("R9", 0, 0);
    wait_ms(52);
    expect_out("R9", 12, 1);

    // R11: power-down during hold
    cur_req = "R11";
    @(negedge clk); pd_i = 1'b1; tone_vld_i = 1'b0;
    @(negedge clk); pd_i = 1'b0;
    expect_out("R11", 0, 0);
    wait_ms(2);

    // R4: fast mode thresholds
    cur_req = "R4";
    fast_i = 1'b1;
    tone(1, 13); wait_ms(30); tone(0, 13); wait_ms(1);
    expect_out("R4", 0, 0);
    tone(1, 14); wait_ms(40);
    expect_out("R4", 14, 1);
    // R7 fast: 2 ms gap bridged
    cur_req = "R7";
    tone(0, 14); wait_ms(2); tone(1, 14); wait_ms(3);
    expect_out("R7", 14, 1);
    // R6 fast: release at 21 ms
    cur_req = "R6";
    tone(0, 14); wait_ms(19);
    expect_out("R6", 14, 1);
    wait_ms(4);
    expect_out("R6", 0, 0);
    wait_ms(2);
    finish_run();
  end
endmodule